// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This block brings a phase-locked frequency synthesizer into service after power is applied. It drives the synthesizer's three-wire configuration port (serial clock, serial data and a latch-enable strobe). On a start request it takes three 24-bit configuration words from its inputs. It shifts them out in a fixed order: the reference-divider word first, then the control word, then the feedback-divider word. A latch-enable pulse commits each word.

Writing the control word is what powers the synthesizer's oscillator up. Its bias currents then need time to settle before the feedback-divider word is committed. The sequencer therefore waits for a settling interval between the second and third words. The length of the wait follows the loop-capacitor option. The large capacitor needs 10 ms and the small one needs 600 µs, both counted in system clock cycles derived from a clock-frequency parameter. A reprogramming pass on a part that is already powered can skip the wait. The busy and done outputs let the surrounding logic follow the pass.

Top module: `synth_init_seq`

## Requirements
- R1: The three words leave in this order: the reference-divider word (`ref_word`), then the control word (`ctl_word`), then the feedback-divider word (`fb_word`). Each of the three latch-enable pulses commits exactly one of them.
- R2: Each word is 24 bits long and is sent most significant bit first. `ser_data` is stable across every rising edge of `ser_clk`. One serial clock period is 2*SCLK_HALF system clock cycles.
- R3: `ser_le` stays low while bits are shifted. After the last bit it is high for exactly one serial clock period (2*SCLK_HALF cycles), and `ser_clk` is low for the whole pulse.
- R4: With `cap_sel`=1 (large capacitor) and `skip_wait`=0, at least SYS_CLK_KHZ*10 system cycles (10 ms) pass between the fall of the control word's latch pulse and the rise of the feedback word's latch pulse.
- R5: With `cap_sel`=0 (small capacitor) and `skip_wait`=0, that gap is at least SYS_CLK_KHZ*3/5 cycles (600 µs). It ends no later than that minimum plus one word's shift time plus a few cycles.
- R6: With `skip_wait`=1 the feedback word follows the control word with no settling interval, so the gap is shorter than the small-capacitor interval.
- R7: `busy` rises in the cycle after an accepted start and stays high until `done`. `done` is high for exactly one cycle after the third latch pulse ends, and `busy` is low in that cycle.
- R8: A start request received while a sequence is in progress is ignored. The pass produces exactly three latch pulses and one `done` pulse.
- R9: The three words, `cap_sel` and `skip_wait` are sampled when a start is accepted. Changing them during a pass does not affect the words sent or the interval used.
- R10: After reset `ser_clk`, `ser_data`, `ser_le`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a programming pass (accepted only when idle) |
| cap_sel | input | 1 | 1 = large loop capacitor (10 ms wait), 0 = small (600 µs wait) |
| skip_wait | input | 1 | 1 = omit the settling interval (reprogramming pass) |
| ref_word | input | WORD_W | Reference-divider configuration word |
| ctl_word | input | WORD_W | Control configuration word |
| fb_word | input | WORD_W | Feedback-divider configuration word |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| ser_le | output | 1 | Latch-enable strobe |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when the pass completes |

## Verification
The assertions check on every cycle the properties that hold at any instant. These are: the step order, exit from the wait only on timer expiry, that a start cannot restart a running pass, that latch enable and serial clock never overlap, that data is stable at each serial clock rise, that the stored words and the idle timer hold, and that done lasts one cycle. Some facts can only be seen by watching whole passes, so the bench's scenarios show them. They are the decoded word values and bit order, the measured pulse widths and clock periods, and the settling gap for each capacitor and skip choice. They also include the effect of changing inputs or re-requesting start in the middle of a pass.

// File: rtl/synth_seq_pkg.sv
// Shared types for the synthesizer power-up sequencer.
// Assumes three configuration words, indexed in their transmit order.
package synth_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SHIFT_R, ST_LATCH_R, ST_SHIFT_C, ST_LATCH_C,
        ST_WAIT, ST_SHIFT_N, ST_LATCH_N, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SM_IDLE, SM_SHIFT, SM_LATCH
    } ser_mode_t;

    // Word index doubles as the transmit position.
    localparam logic [1:0] WSEL_REF = 2'd0;
    localparam logic [1:0] WSEL_CTL = 2'd1;
    localparam logic [1:0] WSEL_FB  = 2'd2;

endpackage

// File: rtl/word_bank.sv
// Holds the configuration words captured when a pass starts.
// Assumes words_in is packed with word 0 in the low bits. In the load
// cycle the selected word is passed straight through, so that a shift
// launched in the same cycle sees the new value.
module word_bank #(
    parameter int WORD_W = 24,
    parameter int NWORDS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NWORDS*WORD_W-1:0] words_in,
    input  logic [1:0]               sel,
    output logic [WORD_W-1:0]        word_out
);

    logic [NWORDS-1:0][WORD_W-1:0] store;

    for (genvar i = 0; i < NWORDS; i++) begin : g_slot
        // Capture one word slot when a pass is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[i] <= '0;
            else if (load)
                store[i] <= words_in[i*WORD_W +: WORD_W];
        end
    end

    // Select the word for the shifter, bypassing during load.
    always_comb begin
        word_out = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (sel == 2'(i))
                word_out = load ? words_in[i*WORD_W +: WORD_W] : store[i];
        end
    end

    // R9: stored words only change on an accepted start
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> store == $past(store));

endmodule

// File: rtl/ser_shifter.sv
// Serializer for the three-wire configuration port.
// A shift command sends one word MSB first. Data changes when the serial
// clock falls and is stable across its rise. A latch command raises the
// latch strobe for one serial period. op_done pulses one cycle after
// either operation ends. Assumes commands arrive only while idle.
module ser_shifter
    import synth_seq_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int SCLK_HALF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_shift,
    input  logic              cmd_latch,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              sdata,
    output logic              le,
    output logic              op_done
);

    localparam int PER   = 2 * SCLK_HALF;
    localparam int PER_W = (PER > 2) ? $clog2(PER) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [PER_W-1:0] LAST_TICK = PER_W'(PER - 1);
    localparam logic [PER_W-1:0] HALF_TICK = PER_W'(SCLK_HALF);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

    ser_mode_t          mode;
    logic [PER_W-1:0]   tick;
    logic [BIT_W-1:0]   bitn;
    logic [WORD_W-1:0]  sreg;

    // Step through bit periods and latch periods, reporting completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= SM_IDLE;
            tick    <= '0;
            bitn    <= '0;
            sreg    <= '0;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            case (mode)
                SM_IDLE: begin
                    tick <= '0;
                    bitn <= '0;
                    if (cmd_shift) begin
                        sreg <= word;
                        mode <= SM_SHIFT;
                    end else if (cmd_latch) begin
                        mode <= SM_LATCH;
                    end
                end
                SM_SHIFT: begin
                    if (tick == LAST_TICK) begin
                        tick <= '0;
                        if (bitn == LAST_BIT) begin
                            mode    <= SM_IDLE;
                            op_done <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sreg <= {sreg[WORD_W-2:0], 1'b0};
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                SM_LATCH: begin
                    if (tick == LAST_TICK) begin
                        tick    <= '0;
                        mode    <= SM_IDLE;
                        op_done <= 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: mode <= SM_IDLE;
            endcase
        end
    end

    // Decode port levels from the current mode and phase.
    assign sclk  = (mode == SM_SHIFT) && (tick >= HALF_TICK);
    assign sdata = (mode == SM_SHIFT) && sreg[WORD_W-1];
    assign le    = (mode == SM_LATCH);

    // R3: strobe and serial clock never high together
    p_le_sclk_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(le && sclk));
    // R2: data does not move on a serial clock rise
    p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));
    // R3: no command accepted while an operation runs
    p_cmd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_shift || cmd_latch) |-> mode == SM_IDLE);

endmodule

// File: rtl/settle_timer.sv
// Down-counter for the oscillator settling interval.
// Loaded with the long or short cycle count, then counts to zero and
// holds there. expired reports the zero count.
module settle_timer #(
    parameter int LONG_CYC  = 2500000,
    parameter int SHORT_CYC = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic expired
);

    localparam int CNT_W = $clog2(LONG_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Load the selected interval, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= long_sel ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: an idle timer never wraps
    p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/seq_ctrl.sv
// Step controller: orders the three word transfers and the settling wait.
// Accepts start only when idle, samples the capacitor and skip choices
// at that moment, and issues one command to the serializer per step.
module seq_ctrl
    import synth_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cap_sel,
    input  logic       skip_wait,
    input  logic       op_done,
    input  logic       wait_over,
    output logic       cmd_shift,
    output logic       cmd_latch,
    output logic [1:0] word_sel,
    output logic       bank_load,
    output logic       timer_load,
    output logic       timer_long,
    output logic       busy,
    output logic       done
);

    seq_state_t state, nxt;
    logic       skip_q;
    logic       cap_q;

    // Advance the step and record the pass options on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            skip_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (bank_load) begin
                skip_q <= skip_wait;
                cap_q  <= cap_sel;
            end
        end
    end

    // Choose the next step and the command launched on the way into it.
    always_comb begin
        nxt        = state;
        cmd_shift  = 1'b0;
        cmd_latch  = 1'b0;
        word_sel   = WSEL_REF;
        bank_load  = 1'b0;
        timer_load = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                nxt       = ST_SHIFT_R;
                cmd_shift = 1'b1;
                bank_load = 1'b1;
            end
            ST_SHIFT_R: if (op_done) begin
                nxt       = ST_LATCH_R;
                cmd_latch = 1'b1;
            end
            ST_LATCH_R: if (op_done) begin
                nxt       = ST_SHIFT_C;
                cmd_shift = 1'b1;
                word_sel  = WSEL_CTL;
            end
            ST_SHIFT_C: if (op_done) begin
                nxt       = ST_LATCH_C;
                cmd_latch = 1'b1;
            end
            ST_LATCH_C: if (op_done) begin
                if (skip_q) begin
                    nxt       = ST_SHIFT_N;
                    cmd_shift = 1'b1;
                    word_sel  = WSEL_FB;
                end else begin
                    nxt        = ST_WAIT;
                    timer_load = 1'b1;
                end
            end
            ST_WAIT: if (wait_over) begin
                nxt       = ST_SHIFT_N;
                cmd_shift = 1'b1;
                word_sel  = WSEL_FB;
            end
            ST_SHIFT_N: if (op_done) begin
                nxt       = ST_LATCH_N;
                cmd_latch = 1'b1;
            end
            ST_LATCH_N: if (op_done) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign timer_long = cap_q;
    assign busy       = (state != ST_IDLE) && (state != ST_DONE);
    assign done       = (state == ST_DONE);

    // R1: control word shift only follows the reference latch
    p_order_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT_C && $past(state) != ST_SHIFT_C) |-> $past(state) == ST_LATCH_R);
    // R1: feedback word shift only follows the control latch or the wait
    p_order_fb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT_N && $past(state) != ST_SHIFT_N)
            |-> ($past(state) == ST_WAIT || $past(state) == ST_LATCH_C));
    // R4: the wait is left only once the timer has expired
    p_wait_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !wait_over) |=> state == ST_WAIT);
    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a running pass cannot be restarted
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_SHIFT_R) |=> state != ST_SHIFT_R);

endmodule

// File: rtl/synth_init_seq.sv
// Top of the synthesizer power-up sequencer.
// Sends three configuration words over a three-wire port with a settling
// wait after the control word. The wait is derived from the system clock
// frequency in kHz: 10 ms for the large capacitor, 600 us for the small one.
module synth_init_seq #(
    parameter int WORD_W      = 24,
    parameter int SCLK_HALF   = 2,
    parameter int SYS_CLK_KHZ = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cap_sel,
    input  logic              skip_wait,
    input  logic [WORD_W-1:0] ref_word,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] fb_word,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              busy,
    output logic              done
);

    localparam int NWORDS    = 3;
    localparam int LONG_CYC  = SYS_CLK_KHZ * 10;
    localparam int SHORT_CYC = (SYS_CLK_KHZ * 3) / 5;

    logic              cmd_shift, cmd_latch, op_done;
    logic              bank_load, timer_load, timer_long, wait_over;
    logic [1:0]        word_sel;
    logic [WORD_W-1:0] cur_word;

    seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cap_sel    (cap_sel),
        .skip_wait  (skip_wait),
        .op_done    (op_done),
        .wait_over  (wait_over),
        .cmd_shift  (cmd_shift),
        .cmd_latch  (cmd_latch),
        .word_sel   (word_sel),
        .bank_load  (bank_load),
        .timer_load (timer_load),
        .timer_long (timer_long),
        .busy       (busy),
        .done       (done)
    );

    word_bank #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bank_load),
        .words_in ({fb_word, ctl_word, ref_word}),
        .sel      (word_sel),
        .word_out (cur_word)
    );

    ser_shifter #(.WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_shift (cmd_shift),
        .cmd_latch (cmd_latch),
        .word      (cur_word),
        .sclk      (ser_clk),
        .sdata     (ser_data),
        .le        (ser_le),
        .op_done   (op_done)
    );

    settle_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .long_sel (timer_long),
        .expired  (wait_over)
    );

    // R7: busy and done never overlap
    p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

// File: tb/sim_synth_init_seq.sv
// Directed bench for the synthesizer power-up sequencer.
module sim_synth_init_seq;

    localparam int W     = 24;
    localparam int HALF  = 2;
    localparam int KHZ   = 500;
    localparam int PER   = 2 * HALF;
    localparam int LONGW = KHZ * 10;       // 10 ms at 500 kHz
    localparam int SHRTW = (KHZ * 3) / 5;  // 600 us at 500 kHz

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cap_sel = 1'b0, skip_wait = 1'b0;
    logic [W-1:0] ref_word = '0, ctl_word = '0, fb_word = '0;
    logic ser_clk, ser_data, ser_le, busy, done;

    synth_init_seq #(.WORD_W(W), .SCLK_HALF(HALF), .SYS_CLK_KHZ(KHZ)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_sel(cap_sel),
        .skip_wait(skip_wait), .ref_word(ref_word), .ctl_word(ctl_word),
        .fb_word(fb_word), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;

    // Bus monitor state
    logic         p_sclk = 1'b0, p_le = 1'b0;
    logic [W-1:0] shr = '0;
    int           nbits = 0, le_n = 0, per_bad = 0, ovl_bad = 0, done_n = 0;
    longint       last_rise = 0;
    logic [W-1:0] rec_word [8];
    int           rec_bits [8];
    longint       le_rise_t [8];
    longint       le_fall_t [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Decode the three-wire port away from the active edge.
    always @(negedge clk) begin
        if (ser_clk && !p_sclk) begin
            if (nbits > 0 && (cyc - last_rise) != PER) per_bad++;
            last_rise = cyc;
            shr = {shr[W-2:0], ser_data};
            nbits++;
        end
        if (ser_le && !p_le) begin
            if (le_n < 8) begin
                rec_word[le_n]  = shr;
                rec_bits[le_n]  = nbits;
                le_rise_t[le_n] = cyc;
            end
            nbits = 0;
        end
        if (!ser_le && p_le) begin
            if (le_n < 8) le_fall_t[le_n] = cyc;
            le_n++;
        end
        if (ser_le && ser_clk) ovl_bad++;
        if (done) done_n++;
        p_sclk = ser_clk;
        p_le   = ser_le;
    end

    task automatic clr_mon();
        nbits = 0; le_n = 0; per_bad = 0; ovl_bad = 0; done_n = 0; shr = '0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // R10: outputs idle after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_clk == 0, "R10", "ser_clk after reset", ser_clk, 0);
        chk(ser_data == 0, "R10", "ser_data after reset", ser_data, 0);
        chk(ser_le == 0, "R10", "ser_le after reset", ser_le, 0);
        chk(busy == 0, "R10", "busy after reset", busy, 0);
        chk(done == 0, "R10", "done after reset", done, 0);
    endtask

    // One full pass; disturb re-requests start and changes inputs mid-pass (R8, R9).
    task automatic t_pass(input logic [W-1:0] r, input logic [W-1:0] c, input logic [W-1:0] n,
                          input bit cap, input bit skip, input bit disturb);
        longint gap, lo, hi;
        int     guard;
        string  wreq;
        ref_word = r; ctl_word = c; fb_word = n; cap_sel = cap; skip_wait = skip;
        clr_mon();
        @(negedge clk) start = 1'b1;
        @(negedge clk) begin
            start = 1'b0;
            chk(busy == 1, "R7", "busy after start", busy, 1);
        end
        if (disturb) begin
            repeat (60) @(negedge clk);
            ref_word = ~r; ctl_word = ~c; fb_word = ~n;
            cap_sel = ~cap; skip_wait = ~skip;
            pulse_start();
            repeat (150) @(negedge clk);
            pulse_start();
        end
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1, "R7", "done reached", done, 1);
        chk(busy == 0, "R7", "busy low with done", busy, 0);
        chk(le_n == 3, "R7", "latch pulses before done", le_n, 3);
        repeat (30) @(negedge clk);
        chk(done_n == 1, "R7", "done pulse cycles", done_n, 1);
        chk(le_n == 3, disturb ? "R8" : "R1", "latch pulses in pass", le_n, 3);
        wreq = disturb ? "R9" : "R1";
        chk(rec_word[0] == r, wreq, "reference word", rec_word[0], r);
        chk(rec_word[1] == c, wreq, "control word", rec_word[1], c);
        chk(rec_word[2] == n, wreq, "feedback word", rec_word[2], n);
        for (int i = 0; i < 3; i++) begin
            chk(rec_bits[i] == W, "R2", "bits per word", rec_bits[i], W);
            chk(le_fall_t[i] - le_rise_t[i] == PER, "R3", "latch pulse width",
                le_fall_t[i] - le_rise_t[i], PER);
        end
        chk(per_bad == 0, "R2", "serial clock period errors", per_bad, 0);
        chk(ovl_bad == 0, "R3", "latch/clock overlap cycles", ovl_bad, 0);
        gap = le_rise_t[2] - le_fall_t[1];
        lo  = skip ? 0 : (cap ? LONGW : SHRTW);
        hi  = lo + W * PER + 10;
        wreq = skip ? "R6" : (cap ? "R4" : "R5");
        chk(gap >= lo, wreq, "settling gap minimum", gap, lo);
        chk(gap <= hi, wreq, "settling gap maximum", gap, hi);
        if (skip) chk(gap < SHRTW, "R6", "skip gap below short wait", gap, SHRTW);
    endtask

    initial begin
        t_reset();
        t_pass(24'hA5C3F1, 24'h3C0F96, 24'h81247E, 1'b0, 1'b0, 1'b0); // R5
        t_pass(24'h800001, 24'hFFFFFF, 24'h000001, 1'b1, 1'b0, 1'b0); // R4
        t_pass(24'h123456, 24'h654321, 24'hFEDCBA, 1'b0, 1'b1, 1'b0); // R6
        t_pass(24'h0F0F0F, 24'hC00003, 24'h5A5A5A, 1'b0, 1'b0, 1'b1); // R8 R9
        t_pass(24'h000000, 24'h7FFFFE, 24'hAAAAAA, 1'b1, 1'b1, 1'b0); // R6 with large cap
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule